// File: doc/BRIEF.md
# Masked Operand Write Guard

This block stands between the processor's operand write path and memory. Software loads an 8-bit mask with a dedicated instruction; at that moment the block also captures the high-order byte of the current program address as a reference. Each bit of the mask that is one pins the matching high-order address bit. From then on, every operand write cycle is checked: each pinned bit of the memory address must equal the reference. A write that breaks the rule is blocked and a protect interrupt is raised.

The interrupt flag stays set until the interrupt logic acknowledges it. Other memory cycles pass through unchecked, with their write enable unchanged. These are instruction fetches, operand reads and writes made by I/O transfers.

Top module: `wr_guard`

## Requirements
- R1: After reset the mask is all zero, the reference is zero and the interrupt flag is clear. With the mask at zero, every operand write is allowed.
- R2: When `maskLoad` is high at a clock edge, the mask takes `maskValue`. In the same edge the reference takes bits 15..8 of `progAddr`.
- R3: An operand write cycle (`opWrite` high together with `wrReq`) passes when `((memAddr[15:8] ^ reference) & mask) == 0`. In that case `memWe` equals `wrReq` in the same cycle, with no register in between.
- R4: An operand write cycle that fails the check drives `memWe` low in that same cycle.
- R5: A failing operand write sets `protIrq` on the next clock edge. `protIrq` stays high until `irqAck` is sampled high at a clock edge.
- R6: When a new violation and `irqAck` arrive at the same edge, the new violation wins and `protIrq` stays high.
- R7: Cycles with `opWrite` low are never checked. `memWe` follows `wrReq` in those cycles and `protIrq` is not set by them.
- R8: A mask load at an edge applies to write cycles from the next cycle on. A write in the same cycle as the load is checked against the old mask and reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| maskLoad | input | 1 | Mask load strobe from the dedicated instruction |
| maskValue | input | 8 | Mask value taken from the instruction operand field |
| progAddr | input | 16 | Current program address, source of the reference byte |
| memAddr | input | 16 | Memory address register value |
| wrReq | input | 1 | Raw memory write request |
| opWrite | input | 1 | Marks the current cycle as an operand write cycle |
| irqAck | input | 1 | Clears the protect interrupt flag |
| memWe | output | 1 | Write enable gated by the check |
| protIrq | output | 1 | Memory protect interrupt flag |

## Verification
The bench builds the block with its default sizes: a 16-bit address and an 8-bit mask over the top byte. This is small enough to sweep every mask bit singly. It also covers the all-ones mask, where only writes inside the reference's 256-word page may pass.

A behavioural model in the bench tracks the mask, the reference and the flag, and compares both outputs on every clock. This exposes the following cases:
- a load and a write in the same cycle;
- an acknowledge colliding with a new violation;
- I/O or fetch cycles that would fail if they were checked.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;
  typedef struct packed {
    logic loadMask;
    logic setIrq;
    logic clrIrq;
  } guardStrobes_t;
endpackage

// File: rtl/wr_guard_dp.sv
module wr_guard_dp #(
  parameter int ADDR_W = 16,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wr_guard_pkg::guardStrobes_t strobes,
  input  logic [MASK_W-1:0] maskValue,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              addrOk,
  output logic              irqFlag
);
  localparam int LSB = ADDR_W - MASK_W;

  logic [MASK_W-1:0] maskReg;
  logic [MASK_W-1:0] refReg;
  logic [MASK_W-1:0] diffBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      refReg  <= '0;
    end else if (strobes.loadMask) begin
      maskReg <= maskValue;
      refReg  <= progAddr[ADDR_W-1:LSB];
    end
  end

  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign diffBits[i] = maskReg[i] & (memAddr[LSB+i] ^ refReg[i]);
  end

  assign addrOk = ~|diffBits;

  always_ff @(posedge clk) begin
    if (!rstN)                irqFlag <= 1'b0;
    else if (strobes.setIrq)  irqFlag <= 1'b1;
    else if (strobes.clrIrq)  irqFlag <= 1'b0;
  end
endmodule

// File: rtl/wr_guard_ctl.sv
module wr_guard_ctl (
  input  logic maskLoad,
  input  logic wrReq,
  input  logic opWrite,
  input  logic irqAck,
  input  logic addrOk,
  output logic memWe,
  output wr_guard_pkg::guardStrobes_t strobes
);
  logic checked;
  logic violation;

  always_comb begin
    checked   = wrReq & opWrite;
    violation = checked & ~addrOk;
    memWe     = wrReq & ~violation;
    strobes.loadMask = maskLoad;
    strobes.setIrq   = violation;
    strobes.clrIrq   = irqAck;
  end
endmodule

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int ADDR_W = 16,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskLoad,
  input  logic [MASK_W-1:0] maskValue,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              wrReq,
  input  logic              opWrite,
  input  logic              irqAck,
  output logic              memWe,
  output logic              protIrq
);
  wr_guard_pkg::guardStrobes_t strobes;
  logic addrOk;

  wr_guard_ctl u_ctl (
    .maskLoad(maskLoad), .wrReq(wrReq), .opWrite(opWrite), .irqAck(irqAck),
    .addrOk(addrOk), .memWe(memWe), .strobes(strobes)
  );

  wr_guard_dp #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .maskValue(maskValue),
    .progAddr(progAddr), .memAddr(memAddr), .addrOk(addrOk), .irqFlag(protIrq)
  );
endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk (
  input logic clk,
  input logic rstN,
  input logic wrReq,
  input logic opWrite,
  input logic irqAck,
  input logic memWe,
  input logic protIrq
);
  logic blocked;
  assign blocked = wrReq & ~memWe;

  AST_WE_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> wrReq); // R3
  AST_BLOCK_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    blocked |=> protIrq); // R5
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (protIrq && !irqAck) |=> protIrq); // R5
  AST_NON_OPERAND_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!opWrite && wrReq) |-> memWe); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !blocked) |=> !protIrq); // R5
  AST_RISE_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protIrq) |-> $past(blocked)); // R4
endmodule

bind wr_guard wr_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .wrReq(wrReq), .opWrite(opWrite),
  .irqAck(irqAck), .memWe(memWe), .protIrq(protIrq)
);

// File: tb/wr_guard_bench.sv
module wr_guard_bench;
  logic clk = 0;
  logic rstN = 0;
  logic maskLoad = 0;
  logic [7:0] maskValue = 0;
  logic [15:0] progAddr = 0, memAddr = 0;
  logic wrReq = 0, opWrite = 0, irqAck = 0;
  logic memWe, protIrq;

  int checks = 0, fails = 0;
  int mMask = 0, mRef = 0;
  bit mIrq = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  wr_guard u_wr_guard (.*);

  function automatic bit passes(int addr);
    return (((addr >> 8) ^ mRef) & mMask & 8'hFF) == 0;
  endfunction

  // compare between edges, mid-low phase
  always @(negedge clk) if (rstN) begin
    bit expWe;
    expWe = wrReq && !(opWrite && !passes(memAddr));
    checks++;
    if (memWe !== expWe) begin
      fails++;
      $display("FAIL %s memWe actual %b expected %b", curReq, memWe, expWe);
    end
    checks++;
    if (protIrq !== mIrq) begin
      fails++;
      $display("FAIL %s protIrq actual %b expected %b", curReq, protIrq, mIrq);
    end
  end

  // model update at edge
  always @(posedge clk) begin
    if (!rstN) begin mMask = 0; mRef = 0; mIrq = 0; end
    else begin
      bit viol;
      viol = wrReq && opWrite && !passes(memAddr);
      if (viol) mIrq = 1; else if (irqAck) mIrq = 0;
      if (maskLoad) begin mMask = maskValue; mRef = progAddr[15:8]; end
    end
  end

  task automatic cyc(input string r, input bit ld, input int mv, input int pa,
                     input int ma, input bit wr, input bit op, input bit ack);
    curReq = r;
    maskLoad = ld; maskValue = mv[7:0]; progAddr = pa[15:0];
    memAddr = ma[15:0]; wrReq = wr; opWrite = op; irqAck = ack;
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rstN = 1;
        @(negedge clk);
        checks++;
        if (protIrq !== 0) begin fails++; $display("FAIL R1 reset irq actual %b expected 0", protIrq); end
        // R1: zero mask lets anything through
        cyc("R1", 0, 0, 0, 16'hFFFF, 1, 1, 0);
        cyc("R1", 0, 0, 0, 16'h1234, 1, 1, 0);
        // R2: load mask, reference from program address
        cyc("R2", 1, 8'hF0, 16'h3A00, 0, 0, 0, 0);
        cyc("R3", 0, 0, 0, 16'h3F12, 1, 1, 0);
        cyc("R4", 0, 0, 0, 16'h4A12, 1, 1, 0);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 0, 1);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0);
        // R7: failing addresses outside operand writes
        cyc("R7", 0, 0, 0, 16'h9900, 1, 0, 0);
        cyc("R7", 0, 0, 0, 16'h9900, 0, 1, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0);
        // R6: ack collides with new violation
        cyc("R6", 0, 0, 0, 16'h0000, 1, 1, 0);
        cyc("R6", 0, 0, 0, 16'h0000, 1, 1, 1);
        cyc("R6", 0, 0, 0, 0, 0, 0, 1);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0);
        // R8: load with same-cycle write uses old mask
        cyc("R8", 1, 8'h00, 16'h0000, 16'h3A00, 1, 1, 0);
        cyc("R8", 0, 0, 0, 16'hFF00, 1, 1, 0);
        cyc("R8", 1, 8'hFF, 16'h5500, 16'hAA00, 1, 1, 0);
        cyc("R8", 0, 0, 0, 16'hAA00, 1, 1, 0);
        cyc("R8", 0, 0, 0, 16'h55FF, 1, 1, 1);
        cyc("R8", 0, 0, 0, 0, 0, 0, 1);
        // R3: single-bit masks against every address bit
        for (int b = 0; b < 8; b++) begin
          cyc("R3", 1, 1 << b, 16'h0000, 0, 0, 0, 0);
          cyc("R3", 0, 0, 0, (16'h0100 << b) ^ 16'hFF00, 1, 1, 0);
          cyc("R4", 0, 0, 0, 16'h0100 << b, 1, 1, 0);
          cyc("R5", 0, 0, 0, 0, 0, 0, 1);
        end
        cyc("R1", 0, 0, 0, 0, 0, 0, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule